// File: doc/BRIEF.md
# Audio clock control sequencer

This block is the digital control logic for a synthesizer that produces several audio system clocks. It runs on the master clock. It does three things. It stretches reset into an initialization window, it chooses where the sampling setting comes from, and it reports when the clock outputs can be trusted again.

While the mode input is high, the setting comes from strap pins: a two-bit group code and a rate pin. While it is low, the setting comes from a seven-bit register that software writes through a one-cycle write strobe. The chosen setting gives four outputs:

- a sampling group (48 kHz, 44.1 kHz or 32 kHz family);
- a standard or double rate flag;
- one enable bit per clock output;
- a two-bit frequency-ratio code per output, which the analog side uses to program its dividers.

Every change of setting, and the end of initialization, starts a settle timer that is counted in master clocks. A `settled` flag rises only when that timer finishes. Group pins that change faster than a minimum spacing set a sticky violation flag.

Top module: `aclk_ctrl_seq`

## Requirements
- R1: When `hw_mode` is 1 the setting follows `grp_pins` and `rate_pin`. When it is 0 the setting follows the software register, and `wr_data` is laid out as [1:0] group, [2] rate, [6:3] output enables (bit 3 = output 0). A write while `hw_mode` is 1 updates only the register and does not change the outputs.
- R2: Group code 00 selects 48 kHz, 01 selects 44.1 kHz and 10 selects 32 kHz, and `grp_sel` shows the accepted code. Code 11 is reserved: it is ignored from either source, and `grp_sel` keeps its previous value. `grp_sel` never reads 11.
- R3: `rate_pin` (or register bit 2) at 0 gives standard rate (`dbl_rate`=0). At 1 it gives double rate (`dbl_rate`=1).
- R4: In strap mode `out_en` is 4'b1111. In software mode `out_en` equals register bits [6:3].
- R5: `init_busy` is 1 while `rst` is 1 or `ext_rst_n` is 0. It stays 1 until `INIT_CYCLES` rising edges have occurred with both released. Throughout that time the outputs hold the defaults: group 00, standard rate, `out_en`=1111.
- R6: The software register returns to the defaults during `init_busy`, and writes made while `init_busy` is 1 are discarded.
- R7: `ratio_code[2i+1:2i]` is the ratio for output i, coded 0 = 256·fs, 1 = 384·fs, 2 = 768·fs, 3 = fixed CD-rate clock. Output 0 is always 3, output 1 is 0 and output 2 is 1. Output 3 is 2 at standard rate and 1 at double rate.
- R8: `settled` is 0 during `init_busy`, and it goes to 0 on the same edge on which any output of the setting changes. It rises exactly `SETTLE_CYCLES` rising edges after the last such change, or after `init_busy` falls.
- R9: In strap mode, two changes of the group pins that are `MIN_GAP_CYCLES` or fewer edges apart set `gap_viol`. Changes spaced further apart do not. `gap_viol` stays set until the next initialization.
- R10: A strap-pin or mode change is seen at the outputs on the third rising edge after it, because of the two-stage synchronizer. A software write is seen on the second rising edge after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n | input | 1 | External reset, active low, synchronous to `clk` |
| hw_mode | input | 1 | 1 = strap-pin control, 0 = register control |
| grp_pins | input | 2 | Strap sampling-group code |
| rate_pin | input | 1 | Strap rate select |
| wr_en | input | 1 | One-cycle software write strobe |
| wr_data | input | 7 | Software register write value |
| init_busy | output | 1 | Initialization window in progress |
| grp_sel | output | 2 | Accepted sampling group |
| dbl_rate | output | 1 | Double-rate flag |
| out_en | output | 4 | Per-output enables |
| ratio_code | output | 8 | Two-bit ratio code per output |
| settled | output | 1 | Settle timer has expired since the last change |
| gap_viol | output | 1 | Sticky group-pin spacing violation |

## Verification
The assertions assume three things about the inputs:

- `ext_rst_n` is already synchronous to the master clock, and it is the only asynchronous-looking input that is not passed through the synchronizer.
- The mode pin and the strap pins can change at any clock.
- Software writes are single-cycle strobes.

The stimulus drives every input on the falling edge, so each input is stable across the rising edge that samples it. Group-pin changes are spaced beyond the minimum interval everywhere except the single test that deliberately violates it. The bench uses short reset, settle and spacing windows, so that each window can be measured edge by edge at its exact boundary.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int NUM_OUT = 4;
  localparam int GRP_W   = 2;
  localparam int RAT_W   = 2;

  typedef enum logic [GRP_W-1:0] {
    GRP_48K  = 2'b00,
    GRP_44K1 = 2'b01,
    GRP_32K  = 2'b10,
    GRP_RSVD = 2'b11
  } grp_e;

  typedef enum logic [RAT_W-1:0] {
    RAT_256   = 2'd0,
    RAT_384   = 2'd1,
    RAT_768   = 2'd2,
    RAT_FIXED = 2'd3
  } ratio_e;

  // Bit layout: [6:3] enables, [2] double rate, [1:0] group
  typedef struct packed {
    logic [NUM_OUT-1:0] en;
    logic               dbl;
    grp_e               grp;
  } setting_t;

  localparam int SET_W = $bits(setting_t);
  localparam setting_t SET_DEFAULT = '{en: {NUM_OUT{1'b1}}, dbl: 1'b0, grp: GRP_48K};
endpackage

// File: rtl/aclk_rst_seq.sv
module aclk_rst_seq #(
  parameter int INIT_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_rst_n,
  output logic busy
);
  localparam int CW = $clog2(INIT_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !ext_rst_n) begin
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == CW'(INIT_CYCLES - 1)) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aclk_sync.sv
module aclk_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/aclk_sel.sv
module aclk_sel
  import aclk_pkg::*;
#(
  parameter int MIN_GAP_CYCLES = 540
) (
  input  logic             clk,
  input  logic             hold,
  input  logic             hw,
  input  logic [GRP_W-1:0] pin_grp,
  input  logic             pin_dbl,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_data,
  output setting_t         cur,
  output logic             chg,
  output logic             viol
);
  localparam int GW = $clog2(MIN_GAP_CYCLES + 1);

  setting_t         sw_q, cand, nxt;
  logic [GW-1:0]    gap_cnt;
  logic [GRP_W-1:0] prev_grp;
  logic             pin_move;

  always_comb begin
    if (hw) cand = '{en: {NUM_OUT{1'b1}}, dbl: pin_dbl, grp: grp_e'(pin_grp)};
    else    cand = sw_q;
    nxt = cand;
    if (cand.grp == GRP_RSVD) nxt.grp = cur.grp;
  end

  assign chg      = !hold && (nxt != cur);
  assign pin_move = hw && (pin_grp != prev_grp);

  always_ff @(posedge clk) begin
    if (hold) begin
      sw_q <= SET_DEFAULT;
      cur  <= SET_DEFAULT;
    end else begin
      if (wr_en) sw_q <= setting_t'(wr_data);
      cur <= nxt;
    end
  end

  always_ff @(posedge clk) begin
    prev_grp <= pin_grp;
    if (hold) begin
      gap_cnt <= GW'(MIN_GAP_CYCLES);
      viol    <= 1'b0;
    end else if (pin_move) begin
      gap_cnt <= '0;
      if (gap_cnt < GW'(MIN_GAP_CYCLES)) viol <= 1'b1;
    end else if (gap_cnt < GW'(MIN_GAP_CYCLES)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/aclk_settle.sv
module aclk_settle #(
  parameter int SETTLE_CYCLES = 540000
) (
  input  logic clk,
  input  logic restart,
  output logic settled
);
  localparam int CW = $clog2(SETTLE_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (restart) begin
      cnt     <= '0;
      settled <= 1'b0;
    end else if (!settled) begin
      if (cnt == CW'(SETTLE_CYCLES - 1)) settled <= 1'b1;
      else                               cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/aclk_ctrl_seq.sv
module aclk_ctrl_seq
  import aclk_pkg::*;
#(
  parameter int INIT_CYCLES    = 1024,
  parameter int SETTLE_CYCLES  = 540000,
  parameter int MIN_GAP_CYCLES = 540,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ext_rst_n,
  input  logic                     hw_mode,
  input  logic [GRP_W-1:0]         grp_pins,
  input  logic                     rate_pin,
  input  logic                     wr_en,
  input  logic [SET_W-1:0]         wr_data,
  output logic                     init_busy,
  output logic [GRP_W-1:0]         grp_sel,
  output logic                     dbl_rate,
  output logic [NUM_OUT-1:0]       out_en,
  output logic [NUM_OUT*RAT_W-1:0] ratio_code,
  output logic                     settled,
  output logic                     gap_viol
);
  localparam int PIN_W = GRP_W + 2;

  logic             hold, chg;
  logic [PIN_W-1:0] pin_s;
  setting_t         cur;

  aclk_rst_seq #(.INIT_CYCLES(INIT_CYCLES)) u_rst (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .busy(init_busy)
  );

  assign hold = rst || !ext_rst_n || init_busy;

  aclk_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({hw_mode, rate_pin, grp_pins}), .q(pin_s)
  );

  aclk_sel #(.MIN_GAP_CYCLES(MIN_GAP_CYCLES)) u_sel (
    .clk(clk), .hold(hold), .hw(pin_s[PIN_W-1]), .pin_grp(pin_s[GRP_W-1:0]),
    .pin_dbl(pin_s[GRP_W]), .wr_en(wr_en), .wr_data(wr_data),
    .cur(cur), .chg(chg), .viol(gap_viol)
  );

  aclk_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .restart(hold || chg), .settled(settled)
  );

  assign grp_sel  = cur.grp;
  assign dbl_rate = cur.dbl;
  assign out_en   = cur.en;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_ratio
    if (i == 0) begin : g_fixed
      assign ratio_code[i*RAT_W +: RAT_W] = RAT_FIXED;
    end else if (i == 1) begin : g_256
      assign ratio_code[i*RAT_W +: RAT_W] = RAT_256;
    end else if (i == 2) begin : g_384
      assign ratio_code[i*RAT_W +: RAT_W] = RAT_384;
    end else begin : g_var
      assign ratio_code[i*RAT_W +: RAT_W] = cur.dbl ? RAT_384 : RAT_768;
    end
  end
endmodule

// File: rtl/aclk_ctrl_seq_chk.sv
module aclk_ctrl_seq_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       ext_rst_n,
  input logic       hw_mode,
  input logic       init_busy,
  input logic [1:0] grp_sel,
  input logic       dbl_rate,
  input logic [3:0] out_en,
  input logic       settled,
  input logic       gap_viol
);
  localparam int RUN_MAX = SYNC_STAGES + 2;
  localparam int RW      = $clog2(RUN_MAX + 1);

  logic [RW-1:0] hw_run;

  always_ff @(posedge clk) begin
    if (rst || !hw_mode)               hw_run <= '0;
    else if (hw_run < RW'(RUN_MAX))    hw_run <= hw_run + 1'b1;
  end

  assert_busy_defaults_R5: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> (grp_sel == 2'b00 && !dbl_rate && out_en == 4'hF));

  assert_ext_reset_R5: assert property (@(posedge clk) disable iff (rst)
    !ext_rst_n |=> init_busy);

  assert_unsettled_in_init_R8: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> !settled);

  assert_change_unsettled_R8: assert property (@(posedge clk) disable iff (rst)
    (!init_busy && (grp_sel != $past(grp_sel) || dbl_rate != $past(dbl_rate)
                    || out_en != $past(out_en))) |-> !settled);

  assert_no_reserved_R2: assert property (@(posedge clk) disable iff (rst)
    grp_sel != 2'b11);

  assert_hw_all_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    (hw_mode && hw_run == RW'(RUN_MAX)) |-> out_en == 4'hF);

  assert_viol_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(gap_viol) && !init_busy) |-> gap_viol);
endmodule

bind aclk_ctrl_seq aclk_ctrl_seq_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .hw_mode(hw_mode),
  .init_busy(init_busy), .grp_sel(grp_sel), .dbl_rate(dbl_rate),
  .out_en(out_en), .settled(settled), .gap_viol(gap_viol)
);

// File: tb/aclk_ctrl_seq_tb.sv
`timescale 1ns/1ps
module aclk_ctrl_seq_tb;
  localparam int INIT   = 16;
  localparam int SETTLE = 40;
  localparam int GAP    = 8;

  logic       clk = 1'b0;
  logic       rst, ext_rst_n, hw_mode, rate_pin, wr_en;
  logic [1:0] grp_pins;
  logic [6:0] wr_data;
  logic       init_busy, dbl_rate, settled, gap_viol;
  logic [1:0] grp_sel;
  logic [3:0] out_en;
  logic [7:0] ratio_code;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  aclk_ctrl_seq #(.INIT_CYCLES(INIT), .SETTLE_CYCLES(SETTLE), .MIN_GAP_CYCLES(GAP)) u_dut (
    .clk(clk), .rst(rst), .ext_rst_n(ext_rst_n), .hw_mode(hw_mode),
    .grp_pins(grp_pins), .rate_pin(rate_pin), .wr_en(wr_en), .wr_data(wr_data),
    .init_busy(init_busy), .grp_sel(grp_sel), .dbl_rate(dbl_rate), .out_en(out_en),
    .ratio_code(ratio_code), .settled(settled), .gap_viol(gap_viol)
  );

  task automatic eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // R7: out3 = 2 (standard) or 1 (double), out2 = 1, out1 = 0, out0 = 3
  function automatic int exp_ratio(input bit d);
    return (d ? 64 : 128) + 16 + 0 + 3;
  endfunction

  task automatic check_state(input string req, input int g, input bit d, input int en);
    eq(req, grp_sel, g);
    eq(req, dbl_rate, d);
    eq(req, out_en, en);
    eq("R7 ratio", ratio_code, exp_ratio(d));
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (init_busy && n < INIT * 4) begin
      step(1);
      n++;
    end
  endtask

  task automatic count_settle(output int n);
    n = 0;
    while (!settled && n < SETTLE * 4) begin
      step(1);
      n++;
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, pg, pen, eg, een;
    bit pd, ed;
    rst = 1; ext_rst_n = 1; hw_mode = 0; grp_pins = 0; rate_pin = 0;
    wr_en = 0; wr_data = 0;
    step(3);
    rst = 0;
    // R5: reset state
    eq("R5 busy", init_busy, 1);
    check_state("R5", 0, 0, 15);
    eq("R8 settled in init", settled, 0);
    // R6: write during busy is discarded
    wr_en = 1; wr_data = 7'b0000_1_10;
    step(1);
    wr_en = 0;
    count_busy(n);
    eq("R5 init length", n + 1, INIT);
    step(1);
    check_state("R6", 0, 0, 15);
    count_settle(n);
    eq("R8 settle after init", n + 1, SETTLE);

    // Software sweep over all register values (R1 R2 R3 R4 R8 R10)
    pg = 0; pd = 0; pen = 15;
    for (int v = 0; v < 128; v++) begin
      wr_en = 1; wr_data = v[6:0];
      step(1);
      wr_en = 0;
      if (v == 5) check_state("R10 sw latency", pg, pd, pen);
      step(1);
      eg = (v[1:0] == 2'b11) ? pg : v[1:0];
      ed = v[2];
      een = v[6:3];
      check_state((v[1:0] == 2'b11) ? "R2 reserved" : "R1 R3 R4 sw", eg, ed, een);
      if (eg != pg || ed != pd || een != pen) eq("R8 change drops settled", settled, 0);
      pg = eg; pd = ed; pen = een;
    end
    wr_en = 1; wr_data = 7'b1111_0_01;
    step(1);
    wr_en = 0;
    step(1);
    eq("R8 settled low on change", settled, 0);
    count_settle(n);
    eq("R8 settle length", n, SETTLE);

    // Mode mux (R1 R4 R10)
    wr_en = 1; wr_data = 7'b0101_0_10;
    step(1);
    wr_en = 0;
    step(1);
    check_state("R1 sw", 2, 0, 5);
    grp_pins = 2'b01; rate_pin = 1; hw_mode = 1;
    step(2);
    check_state("R10 pin latency", 2, 0, 5);
    step(1);
    check_state("R1 R4 hw", 1, 1, 15);
    wr_en = 1; wr_data = 7'b0011_0_00;
    step(1);
    wr_en = 0;
    step(3);
    check_state("R1 write ignored in hw", 1, 1, 15);
    hw_mode = 0;
    step(3);
    check_state("R1 back to sw", 0, 0, 3);
    hw_mode = 1;
    step(3);
    check_state("R1 R4 hw again", 1, 1, 15);
    step(GAP + 2);

    // Strap sweep (R2 R3 R10)
    pg = 1; pd = 1;
    for (int g = 0; g < 4; g++) begin
      for (int r = 0; r < 2; r++) begin
        grp_pins = g[1:0]; rate_pin = r[0];
        step(2);
        check_state("R10 pin latency", pg, pd, 15);
        step(1);
        eg = (g == 3) ? pg : g;
        check_state((g == 3) ? "R2 reserved pins" : "R2 R3 hw", eg, r[0], 15);
        pg = eg; pd = r[0];
        step(GAP + 2);
      end
    end
    eq("R9 no viol when spaced", gap_viol, 0);

    // Spacing boundary (R9)
    grp_pins = 2'b00;
    step(GAP + 1);
    grp_pins = 2'b01;
    step(5);
    eq("R9 spacing GAP+1 ok", gap_viol, 0);
    step(GAP + 2);
    grp_pins = 2'b00;
    step(GAP);
    grp_pins = 2'b01;
    step(5);
    eq("R9 spacing GAP flagged", gap_viol, 1);
    step(50);
    eq("R9 sticky", gap_viol, 1);

    // External reset (R5 R9)
    ext_rst_n = 0;
    step(2);
    eq("R5 ext busy", init_busy, 1);
    eq("R9 cleared by init", gap_viol, 0);
    check_state("R5 ext defaults", 0, 0, 15);
    ext_rst_n = 1;
    count_busy(n);
    eq("R5 ext init length", n, INIT);
    step(1);
    check_state("R1 hw after init", 1, 1, 15);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule